// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask and Routing Controller

This block collects interrupt requests for a small multiprocessor of up to four CPUs and turns them into one 4-bit priority level per CPU. Each CPU owns a register page. The page holds a pending word that covers that CPU's hard lines, its local tick and its software-injected soft levels. Software changes the word through two write-only ports: one sets bits and one clears them. A master page holds the latched system device requests and a mask word that disables sources. The mask word also has write-only set and clear ports. A target register on the master page picks the single CPU that receives all undirected system interrupts.

Software reaches the registers through a simple memory-mapped port. A write takes effect at the clock edge that samples it. A read request is answered one cycle later, with data qualified by a valid strobe. The read side is a two-state machine. In `ACC_IDLE` no data is presented. When a read is sampled the machine moves to `ACC_RESP`, or stays there if it is already there. `ACC_RESP` presents the captured word for exactly one cycle per request. When no read is sampled the machine returns to `ACC_IDLE`.

Each CPU's level output is the highest level among that CPU's pending bits. If the CPU is the current target, the unmasked system sources are included as well, each one mapped to a level through a constant table parameter. The output is 0 when nothing qualifies.

Top module: `mpic_ctrl`

## Requirements
- R1: After reset the mask word reads 0xFFFFFF80, the target register reads 0, every per-CPU pending word reads 0 and every level output is 0.
- R2: A per-CPU set port (page offset 0x8) sets, and a clear port (offset 0x4) clears, only the pending bits written as 1. Bits written as 0 leave the word unchanged. Soft bits change only through these writes.
- R3: Writing 1 to a mask-clear bit (master offset 0x8) enables that system source. Writing 1 to a mask-set bit (master offset 0xC) disables it. The mask word reads back at master offset 0x4.
- R4: While mask bit 31 is 1, no system source reaches any level output, whatever the other mask bits hold.
- R5: In a per-CPU pending word, soft level x sits at bit 16+x and hard level x sits at bit x, for x from 1 to 15. Bits 0 and 16 cannot be set and always read 0.
- R6: A CPU's level output is the highest level among its pending bits, merged with the target's system requests. It is 0 when none apply.
- R7: The system pending word (master offset 0x0) latches the device inputs on bits 30 to 7. The default level table maps bits 30–28 to 15, floppy 22 to 11, module 21 to 9, video 20 to 8, timer 19 to 10, SCSI 18 to 4, audio 17 to 13, Ethernet 16 to 6, serial 15 and keyboard 14 to 12, and bus slot x (bit x+7) to level x+2.
- R8: The target register (master offset 0x10) is readable and writable. Only the CPU it names receives system levels. A written value of NCPU or more is ignored.
- R9: Reads return data one cycle after the request with the valid strobe high for exactly that cycle. Write-only ports and unmapped offsets read 0.
- R10: A CPU's tick input raises hard level 14 in that CPU's own pending word only, whatever the routing target.
- R11: A hard input that is high for one cycle leaves its bit pending until it is cleared. A clear written while the input is still high does not remove the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Byte address; upper bits select a 4 KiB page (CPU c is page c, master is page NCPU) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| cpu_hard_irq | input | NCPU*16 | Hard interrupt lines, 16 per CPU, bit x is level x (bit 0 unused) |
| cpu_tick | input | NCPU | Per-CPU local tick, raises hard level 14 |
| sys_irq | input | 32 | System device request lines, bits 30..7 used |
| cpu_level | output | NCPU*4 | Highest active level per CPU, 0 when idle |

## Verification
A register write changes state at the edge that samples it, so the bench checks the register's effect at the falling edge right after the write cycle. The level outputs are combinational from the registers, so they are checked there too. A change on a device or hard line is captured at the next rising edge, and the bench checks it at the following falling edge. A read answer appears one cycle after the request. The driver queues the expected word when it issues the request, and a falling-edge monitor pops that word and compares it whenever the valid strobe is high.

// File: rtl/mpic_pkg.sv
package mpic_pkg;

    localparam int WORD_W       = 32;
    localparam int LVL_W        = 4;
    localparam int NUM_LVL      = 16;
    localparam int PAGE_BITS    = 12;
    localparam int MASK_ALL_BIT = 31;
    localparam int TICK_LVL     = 14;
    localparam int SOFT_BASE    = 16;

    localparam logic [WORD_W-1:0] HARD_BITS = 32'h0000_FFFE;
    localparam logic [WORD_W-1:0] SOFT_BITS = 32'hFFFE_0000;
    localparam logic [WORD_W-1:0] SRC_BITS  = 32'h7FFF_FF80;
    localparam logic [WORD_W-1:0] MASK_BITS = 32'hFFFF_FF80;

    // per-CPU page offsets
    localparam logic [PAGE_BITS-1:0] OFF_PEND = 12'h000;
    localparam logic [PAGE_BITS-1:0] OFF_CLR  = 12'h004;
    localparam logic [PAGE_BITS-1:0] OFF_SET  = 12'h008;
    // master page offsets
    localparam logic [PAGE_BITS-1:0] OFF_SRC  = 12'h000;
    localparam logic [PAGE_BITS-1:0] OFF_MASK = 12'h004;
    localparam logic [PAGE_BITS-1:0] OFF_MCLR = 12'h008;
    localparam logic [PAGE_BITS-1:0] OFF_MSET = 12'h00C;
    localparam logic [PAGE_BITS-1:0] OFF_TGT  = 12'h010;

    typedef enum logic {
        ACC_IDLE,
        ACC_RESP
    } acc_state_e;

    function automatic logic [WORD_W*LVL_W-1:0] default_src_levels();
        logic [WORD_W*LVL_W-1:0] t;
        t = '0;
        for (int b = 28; b <= 30; b++) begin
            t[b*LVL_W +: LVL_W] = 4'd15;
        end
        t[22*LVL_W +: LVL_W] = 4'd11;
        t[21*LVL_W +: LVL_W] = 4'd9;
        t[20*LVL_W +: LVL_W] = 4'd8;
        t[19*LVL_W +: LVL_W] = 4'd10;
        t[18*LVL_W +: LVL_W] = 4'd4;
        t[17*LVL_W +: LVL_W] = 4'd13;
        t[16*LVL_W +: LVL_W] = 4'd6;
        t[15*LVL_W +: LVL_W] = 4'd12;
        t[14*LVL_W +: LVL_W] = 4'd12;
        for (int s = 0; s < 7; s++) begin
            t[(s+7)*LVL_W +: LVL_W] = LVL_W'(s + 2);
        end
        return t;
    endfunction

endpackage

// File: rtl/mpic_prio.sv
module mpic_prio
    import mpic_pkg::*;
(
    input  logic [NUM_LVL-1:0] req,
    output logic [LVL_W-1:0]   lvl
);

    // ascending scan: the last hit is the highest level; bit 0 yields 0
    always_comb begin
        lvl = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (req[i]) begin
                lvl = LVL_W'(i);
            end
        end
    end

endmodule

// File: rtl/mpic_cpu_win.sv
module mpic_cpu_win
    import mpic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_we,
    input  logic               set_we,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [NUM_LVL-1:0] hard_in,
    input  logic               tick,
    output logic [WORD_W-1:0]  pend_q,
    output logic [NUM_LVL-1:0] lvl_req
);

    localparam logic [WORD_W-1:0] LIVE_BITS = HARD_BITS | SOFT_BITS;

    logic [WORD_W-1:0] line_in;
    logic [WORD_W-1:0] drop;
    logic [WORD_W-1:0] raise;

    assign line_in = ({{(WORD_W-NUM_LVL){1'b0}}, hard_in}
                     | (WORD_W'(tick) << TICK_LVL)) & HARD_BITS;
    assign drop    = clr_we ? (wdata & LIVE_BITS) : '0;
    assign raise   = set_we ? (wdata & LIVE_BITS) : '0;

    // a line still high wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~drop) | raise | line_in;
        end
    end

    assign lvl_req = pend_q[WORD_W-1:SOFT_BASE] | pend_q[SOFT_BASE-1:0];

endmodule

// File: rtl/mpic_master.sv
module mpic_master
    import mpic_pkg::*;
#(
    parameter int                        NCPU       = 4,
    parameter int                        TIDX_W     = 2,
    parameter logic [WORD_W*LVL_W-1:0]   SRC_LEVELS = default_src_levels()
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_clr_we,
    input  logic               mask_set_we,
    input  logic               tgt_we,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [WORD_W-1:0]  src_in,
    output logic [WORD_W-1:0]  mask_q,
    output logic [WORD_W-1:0]  src_pend_q,
    output logic [TIDX_W-1:0]  tgt_q,
    output logic [NUM_LVL-1:0] src_req
);

    logic              tgt_ok;
    logic [WORD_W-1:0] live;

    assign tgt_ok = (wdata < WORD_W'(NCPU));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q     <= MASK_BITS;
            src_pend_q <= '0;
            tgt_q      <= '0;
        end else begin
            src_pend_q <= src_in & SRC_BITS;
            if (mask_clr_we) begin
                mask_q <= mask_q & ~(wdata & MASK_BITS);
            end else if (mask_set_we) begin
                mask_q <= mask_q | (wdata & MASK_BITS);
            end
            if (tgt_we && tgt_ok) begin
                tgt_q <= wdata[TIDX_W-1:0];
            end
        end
    end

    assign live = src_pend_q & ~mask_q & {WORD_W{~mask_q[MASK_ALL_BIT]}};

    always_comb begin
        src_req = '0;
        for (int b = 0; b < WORD_W; b++) begin
            if (live[b]) begin
                src_req[SRC_LEVELS[b*LVL_W +: LVL_W]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mpic_bus_port.sv
module mpic_bus_port
    import mpic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);

    acc_state_e        state_q;
    acc_state_e        state_d;
    logic [WORD_W-1:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (rd_req) begin
            cap_q <= rd_word;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: state_d = rd_req ? ACC_RESP : ACC_IDLE;
            ACC_RESP: state_d = rd_req ? ACC_RESP : ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ACC_RESP: begin
                rvalid = 1'b1;
                rdata  = cap_q;
            end
            default: begin
                rvalid = 1'b0;
                rdata  = '0;
            end
        endcase
    end

endmodule

// File: rtl/mpic_ctrl.sv
module mpic_ctrl
    import mpic_pkg::*;
#(
    parameter int                      NCPU       = 4,
    parameter int                      ADDR_W     = 16,
    parameter logic [WORD_W*LVL_W-1:0] SRC_LEVELS = default_src_levels()
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [WORD_W-1:0]       bus_wdata,
    output logic [WORD_W-1:0]       bus_rdata,
    output logic                    bus_rvalid,
    input  logic [NCPU*NUM_LVL-1:0] cpu_hard_irq,
    input  logic [NCPU-1:0]         cpu_tick,
    input  logic [WORD_W-1:0]       sys_irq,
    output logic [NCPU*LVL_W-1:0]   cpu_level
);

    localparam int PG_W   = ADDR_W - PAGE_BITS;
    localparam int TIDX_W = (NCPU > 1) ? $clog2(NCPU) : 1;

    logic [PG_W-1:0]        page;
    logic [PAGE_BITS-1:0]   off;
    logic                   mst_sel;
    logic [NCPU*WORD_W-1:0] pend_flat;
    logic [WORD_W-1:0]      mask_q;
    logic [WORD_W-1:0]      src_pend_q;
    logic [TIDX_W-1:0]      tgt_q;
    logic [NUM_LVL-1:0]     src_req;
    logic [WORD_W-1:0]      rd_word;

    assign page    = bus_addr[ADDR_W-1:PAGE_BITS];
    assign off     = bus_addr[PAGE_BITS-1:0];
    assign mst_sel = (page == PG_W'(NCPU));

    mpic_master #(
        .NCPU       (NCPU),
        .TIDX_W     (TIDX_W),
        .SRC_LEVELS (SRC_LEVELS)
    ) u_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_clr_we (bus_wr && mst_sel && off == OFF_MCLR),
        .mask_set_we (bus_wr && mst_sel && off == OFF_MSET),
        .tgt_we      (bus_wr && mst_sel && off == OFF_TGT),
        .wdata       (bus_wdata),
        .src_in      (sys_irq),
        .mask_q      (mask_q),
        .src_pend_q  (src_pend_q),
        .tgt_q       (tgt_q),
        .src_req     (src_req)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic                 hit;
        logic [WORD_W-1:0]    pend;
        logic [NUM_LVL-1:0]   own_req;
        logic [NUM_LVL-1:0]   all_req;

        assign hit = (page == PG_W'(c));

        mpic_cpu_win u_win (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_we  (bus_wr && hit && off == OFF_CLR),
            .set_we  (bus_wr && hit && off == OFF_SET),
            .wdata   (bus_wdata),
            .hard_in (cpu_hard_irq[c*NUM_LVL +: NUM_LVL]),
            .tick    (cpu_tick[c]),
            .pend_q  (pend),
            .lvl_req (own_req)
        );

        // undirected system requests join only the target CPU
        assign all_req = own_req | ((tgt_q == TIDX_W'(c)) ? src_req : '0);

        mpic_prio u_prio (
            .req (all_req),
            .lvl (cpu_level[c*LVL_W +: LVL_W])
        );

        assign pend_flat[c*WORD_W +: WORD_W] = pend;
    end

    always_comb begin
        rd_word = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (page == PG_W'(c) && off == OFF_PEND) begin
                rd_word = pend_flat[c*WORD_W +: WORD_W];
            end
        end
        if (mst_sel) begin
            case (off)
                OFF_SRC:  rd_word = src_pend_q;
                OFF_MASK: rd_word = mask_q;
                OFF_TGT:  rd_word = WORD_W'(tgt_q);
                default:  rd_word = '0;
            endcase
        end
    end

    mpic_bus_port u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (bus_rd),
        .rd_word (rd_word),
        .rdata   (bus_rdata),
        .rvalid  (bus_rvalid)
    );

endmodule

// File: rtl/mpic_ctrl_chk.sv
module mpic_ctrl_chk
    import mpic_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int TIDX_W = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic                    bus_rd,
    input logic                    bus_rvalid,
    input logic [WORD_W-1:0]       mask_q,
    input logic [TIDX_W-1:0]       tgt_q,
    input logic [NCPU*WORD_W-1:0]  pend_flat,
    input logic [NCPU*LVL_W-1:0]   cpu_level
);

    // R9
    read_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R9
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    // R3
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(mask_q));

    // R8
    target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(tgt_q));

    for (genvar c = 0; c < NCPU; c++) begin : g_chk
        // R2
        soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_wr |=> $stable(pend_flat[c*WORD_W+SOFT_BASE +: SOFT_BASE]));

        // R6
        idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_flat[c*WORD_W +: WORD_W] == '0 && tgt_q != TIDX_W'(c))
            |-> cpu_level[c*LVL_W +: LVL_W] == '0);

        // R4
        mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_flat[c*WORD_W +: WORD_W] == '0 && mask_q[MASK_ALL_BIT])
            |-> cpu_level[c*LVL_W +: LVL_W] == '0);
    end

endmodule

bind mpic_ctrl mpic_ctrl_chk #(
    .NCPU   (NCPU),
    .TIDX_W (TIDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rvalid (bus_rvalid),
    .mask_q     (mask_q),
    .tgt_q      (tgt_q),
    .pend_flat  (pend_flat),
    .cpu_level  (cpu_level)
);

// File: tb/test_mpic_ctrl.sv
`timescale 1ns/1ps
module test_mpic_ctrl;

    localparam int NCPU   = 4;
    localparam int ADDR_W = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                bus_wr = 1'b0;
    logic                bus_rd = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic                bus_rvalid;
    logic [NCPU*16-1:0]  cpu_hard_irq = '0;
    logic [NCPU-1:0]     cpu_tick = '0;
    logic [31:0]         sys_irq = '0;
    logic [NCPU*4-1:0]   cpu_level;

    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] exp_w;
    string       exp_t;

    always #2 clk = ~clk;

    mpic_ctrl #(.NCPU(NCPU), .ADDR_W(ADDR_W)) i_mpic_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_rvalid   (bus_rvalid),
        .cpu_hard_irq (cpu_hard_irq),
        .cpu_tick     (cpu_tick),
        .sys_irq      (sys_irq),
        .cpu_level    (cpu_level)
    );

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: queue the expected word, then issue the request
    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_lvl(input int c, input logic [3:0] e, input string tag);
        n_run++;
        if (cpu_level[c*4 +: 4] !== e) begin
            n_fail++;
            $display("FAIL %s cpu%0d level: got %0d expected %0d", tag, c, cpu_level[c*4 +: 4], e);
        end
    endtask

    task automatic drive_sys(input logic [31:0] v);
        @(negedge clk);
        sys_irq = v;
        @(negedge clk);
    endtask

    // monitor: one queued word per valid cycle
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R9 unexpected read data: got %h expected none", bus_rdata);
            end else begin
                exp_w = exp_q.pop_front();
                exp_t = tag_q.pop_front();
                if (bus_rdata !== exp_w) begin
                    n_fail++;
                    $display("FAIL %s read: got %h expected %h", exp_t, bus_rdata, exp_w);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int c = 0; c < NCPU; c++) chk_lvl(c, 4'd0, "R1");
        rd(16'h4004, 32'hFFFF_FF80, "R1 mask");
        rd(16'h4010, 32'h0, "R1 target");
        rd(16'h0000, 32'h0, "R1 cpu0 pending");

        // R2 / R6 soft set and clear on cpu1
        wr(16'h1008, 32'h0020_0000);
        rd(16'h1000, 32'h0020_0000, "R2 set soft 5");
        chk_lvl(1, 4'd5, "R6 soft 5");
        chk_lvl(0, 4'd0, "R6 other cpu");
        wr(16'h1008, 32'h0);
        wr(16'h1004, 32'h0);
        wr(16'h1004, 32'h0040_0000);
        rd(16'h1000, 32'h0020_0000, "R2 zero bits ignored");
        wr(16'h1008, 32'h8000_0000);
        chk_lvl(1, 4'd15, "R6 highest");
        wr(16'h1004, 32'h8000_0000);
        chk_lvl(1, 4'd5, "R6 after clear");
        wr(16'h1004, 32'h0020_0000);
        chk_lvl(1, 4'd0, "R6 none");
        rd(16'h1000, 32'h0, "R2 cleared");

        // R5 layout
        wr(16'h2008, 32'h0001_0001);
        rd(16'h2000, 32'h0, "R5 bits 0 and 16");
        chk_lvl(2, 4'd0, "R5 no level");
        wr(16'h2008, 32'h0000_0008);
        rd(16'h2000, 32'h0000_0008, "R5 hard 3");
        chk_lvl(2, 4'd3, "R5 hard level");
        wr(16'h2004, 32'h0000_0008);

        // R9 write-only ports
        rd(16'h2004, 32'h0, "R9 clear port");
        rd(16'h4008, 32'h0, "R9 mask clear port");
        rd(16'h400C, 32'h0, "R9 mask set port");

        // R11 hard line latching
        @(negedge clk); cpu_hard_irq[3*16+7] = 1'b1;
        @(negedge clk); cpu_hard_irq[3*16+7] = 1'b0;
        rd(16'h3000, 32'h0000_0080, "R11 latched");
        chk_lvl(3, 4'd7, "R11 level");
        wr(16'h3004, 32'h0000_0080);
        rd(16'h3000, 32'h0, "R11 cleared");
        @(negedge clk); cpu_hard_irq[3*16+9] = 1'b1;
        wr(16'h3004, 32'h0000_0200);
        rd(16'h3000, 32'h0000_0200, "R11 line wins");
        cpu_hard_irq[3*16+9] = 1'b0;
        wr(16'h3004, 32'h0000_0200);
        chk_lvl(3, 4'd0, "R11 released");

        // R10 local tick
        @(negedge clk); cpu_tick[2] = 1'b1;
        @(negedge clk); cpu_tick[2] = 1'b0;
        chk_lvl(2, 4'd14, "R10 tick");
        chk_lvl(0, 4'd0, "R10 not routed");
        rd(16'h2000, 32'h0000_4000, "R10 bit 14");
        wr(16'h2004, 32'h0000_4000);

        // R7 / R3 / R4 / R8 system routing
        drive_sys(32'h0004_0000);
        chk_lvl(0, 4'd0, "R4 reset mask");
        rd(16'h4000, 32'h0004_0000, "R7 source pending");
        wr(16'h4008, 32'h0004_0000);
        chk_lvl(0, 4'd0, "R4 mask-all holds");
        wr(16'h4008, 32'h8000_0000);
        chk_lvl(0, 4'd4, "R7 scsi level");
        rd(16'h4004, 32'h7FFB_FF80, "R3 mask value");
        drive_sys(32'h000C_0000);
        chk_lvl(0, 4'd4, "R3 timer still masked");
        wr(16'h4008, 32'h0008_0000);
        chk_lvl(0, 4'd10, "R7 timer level");
        wr(16'h4010, 32'h2);
        chk_lvl(2, 4'd10, "R8 routed to cpu2");
        chk_lvl(0, 4'd0, "R8 cpu0 dropped");
        wr(16'h4010, 32'h7);
        rd(16'h4010, 32'h2, "R8 out of range ignored");
        chk_lvl(2, 4'd10, "R8 still cpu2");
        wr(16'h400C, 32'h0008_0000);
        chk_lvl(2, 4'd4, "R3 set disables");
        wr(16'h400C, 32'h8000_0000);
        chk_lvl(2, 4'd0, "R4 mask-all set");
        rd(16'h4004, 32'hFFFB_FF80, "R3 mask readback");
        wr(16'h4008, 32'h8000_0000);
        chk_lvl(2, 4'd4, "R4 mask-all cleared");
        wr(16'h2008, 32'h0004_0000);
        chk_lvl(2, 4'd4, "R6 merge soft 2");
        wr(16'h2008, 32'h0200_0000);
        chk_lvl(2, 4'd9, "R6 merge soft 9");

        repeat (3) @(negedge clk);
        n_run++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9 missing read answers: got %0d left expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule